// File: doc/BRIEF.md
# Outbound I/O Address Decoder

This block sorts each outbound I/O read or write from a processor-side request port into one of four routing classes. The classes are legacy video, compatibility bus, configuration, and default. Each request gives a 16-bit start address, a byte count of one to four, and a read/write flag. The block checks every byte the request touches against the legacy windows that are switched on. Those windows are the video ranges, the ISA alias ranges, and the 4KB regions that a redirection bitmap marks. The block also compares the start address against the two configuration ports.

A fixed priority decides between windows that overlap. The decoded class is captured in a register, together with a flag that marks a configuration access aimed at this node itself. The register holds its value until the downstream side accepts it. Port selection further along, the contents of the configuration registers, and the data path are handled elsewhere.

Top module: `io_route_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `req_ready` is 1.
- R2: When `vga_en` is 1 and every byte the request covers has A[9:0] in 3B0h–3BBh or 3C0h–3DFh, `out_attr` is 1 (video class). A[15:10] play no part in this test.
- R3: If any one covered byte falls outside both video ranges, the request is not the video class. For example, two bytes starting at 23BBh fail the test.
- R4: A 4-byte access (`req_size`=3) that starts at 0CF8h gives `out_attr`=3 (configuration) with `out_internal`=1. An access of any size that starts at 0CFCh while `cfg_space_en`=1 also gives `out_attr`=3. For it, `out_internal`=1 only when `cfg_bus`==`node_bus` and `cfg_dev`==`node_dev`. With `cfg_space_en`=0, 0CFCh is not a configuration access. `out_internal` is 1 only with `out_attr`=3.
- R5: When `alias_en` is 1 and every covered byte has A[9:8] not equal to 00, the request gives `out_attr`=2 (compatibility bus). These are the offsets x100h–x3FFh, x500h–x7FFh, x900h–xBFFh and xD00h–xFFFh of each 4KB page.
- R6: When bit A[15:12] of `redir_map` is set for every covered byte, the request gives `out_attr`=2.
- R7: The classes are tried in this order: video, configuration, ISA alias, redirection. A request that matches none of them gives `out_attr`=0 (default).
- R8: A request covers `req_size`+1 bytes, from the start address upward, and the address wraps at 16 bits (FFFFh is followed by 0000h).
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The result appears on the next cycle with `out_valid`=1 and `out_write` equal to `req_write`. `req_ready` is `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values.
- R10: With `vga_en`=0 the video class never appears. With `alias_en`=0 and `redir_map`=0 the compatibility bus class never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 16 | Start I/O address |
| req_size | input | 2 | Byte count minus one |
| req_write | input | 1 | 1 = write, 0 = read |
| vga_en | input | 1 | Enable video window decode |
| alias_en | input | 1 | Enable ISA alias decode |
| redir_map | input | 16 | One redirect bit per 4KB region |
| cfg_space_en | input | 1 | Configuration data port enabled |
| cfg_bus | input | 8 | Bus field of configuration address |
| cfg_dev | input | 5 | Device field of configuration address |
| node_bus | input | 8 | This node's bus number |
| node_dev | input | 5 | This node's device number |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Downstream accepts result |
| out_attr | output | 2 | 0 default, 1 video, 2 compatibility bus, 3 configuration |
| out_internal | output | 1 | Configuration access targets this node |
| out_write | output | 1 | Registered read/write flag |

## Verification
Single-byte requests at the edges of the video ranges, some with high address bits set, show that only the low ten bits are compared. Multi-byte requests that run across a range boundary separate a check on every byte from a check on the start byte only. Overlapping cases show that the priority is applied: a video address that is also an alias, and a configuration port inside a redirected region. Switching `vga_en` between two such requests separates priority from the enable gating. A redirected region paired with a request that wraps past FFFFh, and a request that is stalled by downstream back-pressure, cover the span arithmetic and the hold rule.

// File: rtl/io_route_pkg.sv
package io_route_pkg;
   typedef enum logic [1:0] {
      ATTR_DND = 2'd0,
      ATTR_VGA = 2'd1,
      ATTR_CB  = 2'd2,
      ATTR_CFG = 2'd3
   } route_attr_e;
endpackage

// File: rtl/io_byte_window.sv
module io_byte_window #(
   parameter int ADDR_W   = 16,
   parameter int REDIR_W  = 16,
   parameter bit REDIR_EN = 1'b1
) (
   input  logic [ADDR_W-1:0]  byte_addr,
   input  logic [REDIR_W-1:0] redir_map,
   output logic               hit_vga,
   output logic               hit_alias,
   output logic               hit_redir
);
   logic [9:0] off10;
   assign off10 = byte_addr[9:0];

   // video ranges, top address bits ignored
   assign hit_vga = ((off10 >= 10'h3B0) && (off10 <= 10'h3BB)) ||
                    ((off10 >= 10'h3C0) && (off10 <= 10'h3DF));

   // alias: upper three quarters of each 1KB block
   assign hit_alias = |byte_addr[9:8];

   generate
      if (REDIR_EN) begin : g_redir
         assign hit_redir = redir_map[byte_addr[ADDR_W-1:12]];
      end else begin : g_no_redir
         assign hit_redir = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/io_cfg_match.sv
module io_cfg_match #(
   parameter int ADDR_W = 16,
   parameter int SIZE_W = 2,
   parameter int BUS_W  = 8,
   parameter int DEV_W  = 5
) (
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [SIZE_W-1:0] size,
   input  logic              cfg_space_en,
   input  logic [BUS_W-1:0]  cfg_bus,
   input  logic [DEV_W-1:0]  cfg_dev,
   input  logic [BUS_W-1:0]  node_bus,
   input  logic [DEV_W-1:0]  node_dev,
   output logic              is_cfg,
   output logic              is_local
);
   localparam logic [ADDR_W-1:0] PORT_SEL  = ADDR_W'(16'h0CF8);
   localparam logic [ADDR_W-1:0] PORT_DATA = ADDR_W'(16'h0CFC);
   localparam logic [SIZE_W-1:0] DWORD     = SIZE_W'(3);

   logic sel_hit, data_hit, id_match;

   assign sel_hit  = (start_addr == PORT_SEL) && (size == DWORD);
   assign data_hit = (start_addr == PORT_DATA) && cfg_space_en;
   assign id_match = (cfg_bus == node_bus) && (cfg_dev == node_dev);

   assign is_cfg   = sel_hit | data_hit;
   // the selector register itself lives in this node
   assign is_local = sel_hit | (data_hit & id_match);
endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
   import io_route_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MAX_BYTES = 4,
   parameter int BUS_W     = 8,
   parameter int DEV_W     = 5,
   parameter bit REDIR_EN  = 1'b1,
   localparam int SIZE_W   = $clog2(MAX_BYTES),
   localparam int REDIR_W  = 1 << (ADDR_W - 12)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic               req_write,
   input  logic               vga_en,
   input  logic               alias_en,
   input  logic [REDIR_W-1:0] redir_map,
   input  logic               cfg_space_en,
   input  logic [BUS_W-1:0]   cfg_bus,
   input  logic [DEV_W-1:0]   cfg_dev,
   input  logic [BUS_W-1:0]   node_bus,
   input  logic [DEV_W-1:0]   node_dev,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [1:0]         out_attr,
   output logic               out_internal,
   output logic               out_write
);
   generate
      if (ADDR_W < 12 || ADDR_W > 20) begin : g_bad_addr
         $error("ADDR_W must lie in 12..20");
      end
      if (MAX_BYTES < 4 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_bytes
         $error("MAX_BYTES must be a power of two, at least 4");
      end
   endgenerate

   logic [MAX_BYTES-1:0] vga_ok, alias_ok, redir_ok;

   generate
      for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
         localparam logic [SIZE_W:0] LANE = (SIZE_W+1)'(i);
         logic [ADDR_W-1:0] lane_addr;
         logic lane_on, h_vga, h_alias, h_redir;

         assign lane_addr = req_addr + ADDR_W'(i);
         assign lane_on   = LANE <= {1'b0, req_size};

         io_byte_window #(
            .ADDR_W(ADDR_W), .REDIR_W(REDIR_W), .REDIR_EN(REDIR_EN)
         ) u_win (
            .byte_addr(lane_addr), .redir_map(redir_map),
            .hit_vga(h_vga), .hit_alias(h_alias), .hit_redir(h_redir)
         );

         assign vga_ok[i]   = h_vga   | ~lane_on;
         assign alias_ok[i] = h_alias | ~lane_on;
         assign redir_ok[i] = h_redir | ~lane_on;
      end
   endgenerate

   logic cfg_hit, cfg_local;

   io_cfg_match #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BUS_W(BUS_W), .DEV_W(DEV_W)
   ) u_cfg (
      .start_addr(req_addr), .size(req_size), .cfg_space_en(cfg_space_en),
      .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .node_bus(node_bus), .node_dev(node_dev),
      .is_cfg(cfg_hit), .is_local(cfg_local)
   );

   route_attr_e next_attr;
   logic        next_internal;

   always_comb begin
      next_internal = 1'b0;
      if (vga_en && (&vga_ok)) begin
         next_attr = ATTR_VGA;
      end else if (cfg_hit) begin
         next_attr     = ATTR_CFG;
         next_internal = cfg_local;
      end else if (alias_en && (&alias_ok)) begin
         next_attr = ATTR_CB;
      end else if (&redir_ok) begin
         next_attr = ATTR_CB;
      end else begin
         next_attr = ATTR_DND;
      end
   end

   assign req_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_attr     <= ATTR_DND;
         out_internal <= 1'b0;
         out_write    <= 1'b0;
      end else if (req_valid && req_ready) begin
         out_valid    <= 1'b1;
         out_attr     <= next_attr;
         out_internal <= next_internal;
         out_write    <= req_write;
      end else if (out_ready) begin
         out_valid    <= 1'b0;
      end
   end
endmodule

// File: rtl/io_route_checker.sv
module io_route_checker #(
   parameter int REDIR_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               req_write,
   input logic               vga_en,
   input logic               alias_en,
   input logic [REDIR_W-1:0] redir_map,
   input logic               out_valid,
   input logic               out_ready,
   input logic [1:0]         out_attr,
   input logic               out_internal,
   input logic               out_write
);
   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !req_ready);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_attr)
                                     && $stable(out_internal) && $stable(out_write)));

   assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (out_valid && out_write == $past(req_write)));

   assert_novga_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !vga_en) |=> (out_attr != 2'd1));

   assert_nocb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !alias_en && redir_map == '0) |=> (out_attr != 2'd2));

   assert_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_internal) |-> (out_attr == 2'd3));
endmodule

bind io_route_decoder io_route_checker #(.REDIR_W(REDIR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_write(req_write), .vga_en(vga_en), .alias_en(alias_en),
   .redir_map(redir_map), .out_valid(out_valid), .out_ready(out_ready),
   .out_attr(out_attr), .out_internal(out_internal), .out_write(out_write)
);

// File: tb/io_route_decoder_test.sv
module io_route_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic        vga_en = 1'b0;
   logic        alias_en = 1'b0;
   logic [15:0] redir_map = '0;
   logic        cfg_space_en = 1'b0;
   logic [7:0]  cfg_bus = '0;
   logic [4:0]  cfg_dev = '0;
   logic [7:0]  node_bus = 8'h05;
   logic [4:0]  node_dev = 5'h03;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [1:0]  out_attr;
   logic        out_internal;
   logic        out_write;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [1:0] attr;
      logic       intl;
      logic       wr;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;  // 50 MHz

   io_route_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
      .vga_en(vga_en), .alias_en(alias_en), .redir_map(redir_map),
      .cfg_space_en(cfg_space_en), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
      .node_bus(node_bus), .node_dev(node_dev),
      .out_valid(out_valid), .out_ready(out_ready), .out_attr(out_attr),
      .out_internal(out_internal), .out_write(out_write)
   );

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %s expected %s", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                       input logic [1:0] e_attr, input logic e_int, input string tag);
      exp_t e;
      @(negedge clk);
      req_addr  = a;
      req_size  = sz;
      req_write = wr;
      req_valid = 1'b1;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      e.attr = e_attr; e.intl = e_int; e.wr = wr; e.tag = tag;
      exp_q.push_back(e);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   // monitor: a transfer happens at the next edge when valid and ready
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected output", $sformatf("attr=%0d", out_attr), "none");
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(out_attr == e.attr && out_internal == e.intl && out_write == e.wr, e.tag,
                     $sformatf("attr=%0d int=%0d wr=%0d", out_attr, out_internal, out_write),
                     $sformatf("attr=%0d int=%0d wr=%0d", e.attr, e.intl, e.wr));
            end
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      check(out_valid == 1'b0 && req_ready == 1'b1, "R1 reset state",
            $sformatf("valid=%0d ready=%0d", out_valid, req_ready), "valid=0 ready=1");

      // video windows
      vga_en = 1'b1;
      send(16'h03B0, 2'd0, 1'b0, 2'd1, 1'b0, "R2 single byte 3B0");
      send(16'hF3DF, 2'd0, 1'b1, 2'd1, 1'b0, "R2 high bits ignored F3DF");
      send(16'h03B8, 2'd3, 1'b0, 2'd1, 1'b0, "R2 four bytes 3B8-3BB");
      send(16'h23BB, 2'd1, 1'b0, 2'd0, 1'b0, "R3 two bytes 23BB-23BC");
      send(16'h03BE, 2'd3, 1'b1, 2'd0, 1'b0, "R3 span 3BE-3C1");

      // configuration ports
      cfg_space_en = 1'b1; cfg_bus = 8'h05; cfg_dev = 5'h03;
      send(16'h0CF8, 2'd3, 1'b1, 2'd3, 1'b1, "R4 dword selector");
      send(16'h0CF8, 2'd1, 1'b0, 2'd0, 1'b0, "R4 short selector not config");
      send(16'h0CFC, 2'd0, 1'b0, 2'd3, 1'b1, "R4 data port local");
      cfg_bus = 8'h06;
      send(16'h0CFC, 2'd3, 1'b1, 2'd3, 1'b0, "R4 data port remote bus");
      cfg_bus = 8'h05; cfg_dev = 5'h04;
      send(16'h0CFC, 2'd2, 1'b0, 2'd3, 1'b0, "R4 data port remote device");
      cfg_dev = 5'h03; cfg_space_en = 1'b0;
      send(16'h0CFC, 2'd0, 1'b0, 2'd0, 1'b0, "R4 data port disabled");

      // ISA aliases and priority
      alias_en = 1'b1;
      send(16'h1100, 2'd3, 1'b0, 2'd2, 1'b0, "R5 alias 1100-1103");
      send(16'h10FE, 2'd3, 1'b0, 2'd0, 1'b0, "R5 partial alias 10FE");
      send(16'h03C0, 2'd0, 1'b0, 2'd1, 1'b0, "R7 video over alias");
      vga_en = 1'b0;
      send(16'h03C0, 2'd0, 1'b1, 2'd2, 1'b0, "R10 video off gives alias");
      alias_en = 1'b0;
      send(16'h03B0, 2'd0, 1'b0, 2'd0, 1'b0, "R10 all windows off");

      // redirection
      redir_map = 16'h0020;
      send(16'h5000, 2'd3, 1'b0, 2'd2, 1'b0, "R6 redirected region 5");
      send(16'h5FFE, 2'd3, 1'b0, 2'd0, 1'b0, "R6 span leaves region");
      redir_map = 16'h0060;
      send(16'h5FFE, 2'd3, 1'b1, 2'd2, 1'b0, "R6 span in regions 5 and 6");
      redir_map = 16'h8000;
      send(16'hFFFF, 2'd1, 1'b0, 2'd0, 1'b0, "R8 wrap into region 0");
      redir_map = 16'h8001;
      send(16'hFFFF, 2'd1, 1'b0, 2'd2, 1'b0, "R8 wrap both regions");
      alias_en = 1'b1; redir_map = 16'h0001;
      send(16'h0CF8, 2'd3, 1'b0, 2'd3, 1'b1, "R7 config over redirect");

      // back-pressure
      repeat (3) @(negedge clk);
      out_ready = 1'b0;
      send(16'h0100, 2'd0, 1'b1, 2'd2, 1'b0, "R9 held item");
      repeat (3) @(negedge clk);
      #2;
      check(out_valid == 1'b1 && req_ready == 1'b0 && out_attr == 2'd2 && out_write == 1'b1,
            "R9 stall hold",
            $sformatf("valid=%0d ready=%0d attr=%0d wr=%0d", out_valid, req_ready, out_attr, out_write),
            "valid=1 ready=0 attr=2 wr=1");
      @(negedge clk);
      out_ready = 1'b1;

      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, "R9 all results delivered",
            $sformatf("%0d", exp_q.size()), "0");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule